// File: doc/BRIEF.md
# Slave-Mode ATM Cell Receive Port

This block receives ATM cells from a physical-layer device that owns the bus timing. On each rising edge of the receive clock where the PHY pulls its active-low enable low, the block takes in one 16-bit word and its parity bit. A start-of-cell marker that arrives with the first word of a cell sets the framing. Complete cells of 27 words go into an internal FIFO that holds four cells. The block does not throttle single words. It sends back one flag that goes active when the FIFO has no room left for another whole cell.

Every word that is taken in gets an odd-parity check over its data and parity bit. Any failure sets a sticky error bit. If the halt control input is high, a parity failure also throws away the cell in progress, and the block takes no more words until software pulses the clear strobe. The same strobe clears the overflow bit, which records words that arrived while the FIFO was full. After a clear, the block waits for a fresh start-of-cell. On the downstream side the block presents words with valid/ready handshaking, and it tags the first word of each cell.

Top module: `utopia_rx_slave`

## Requirements
- R1: A word is sampled only on a clock edge where `rx_en_n` is 0. Data, parity and start-of-cell values present while `rx_en_n` is 1 have no effect on the stored cells or the flags.
- R2: A sampled word passes parity when the XOR of `rx_data[15:0]` and `rx_par` is 1 (odd ones count). On a failure, `par_err` goes to 1 and stays at 1 until `clr_status`.
- R3: When `halt_on_par` is 1, a word that fails parity is discarded along with the partial cell it belongs to, and `halted` goes to 1. While `halted` is 1, all words are ignored, and this remains so until `clr_status`.
- R4: When `halt_on_par` is 0, a word that fails parity is stored like any other word, and its cell completes normally.
- R5: A cell starts with a word that has `rx_soc` at 1 and holds exactly 27 words. Words that have no cell open are dropped. A start-of-cell in the middle of a cell abandons the partial cell and begins a new one.
- R6: A cell can be seen on the read side only after its 27th word has been written.
- R7: `cell_full` is 1 exactly when four complete cells are stored and unread, and it returns to 0 once the last word of the oldest cell has been read.
- R8: A sampled word that arrives while `cell_full` is 1 is dropped and sets the sticky `ovf_err`. Cells that are already stored are not changed.
- R9: Cells are read in order. `rd_valid` is high while a complete cell is stored, a word is consumed on a cycle with `rd_valid` and `rd_ready`, and `rd_soc` marks word 0 of each cell. A word that is held stays stable until it is consumed.
- R10: `clr_status` clears `par_err`, `ovf_err` and `halted`. It also closes any open cell, so words that follow are dropped until the next start-of-cell.
- R11: After reset, `rd_valid`, `cell_full`, `par_err`, `ovf_err` and `halted` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_en_n | input | 1 | Active-low word enable driven by the PHY |
| rx_data | input | 16 | Receive word |
| rx_par | input | 1 | Odd-parity bit for rx_data |
| rx_soc | input | 1 | Start-of-cell marker for the current word |
| halt_on_par | input | 1 | Discard and halt on parity failure |
| clr_status | input | 1 | Clears the sticky flags and the halt, and resynchronises framing |
| cell_full | output | 1 | No room for another complete cell |
| par_err | output | 1 | Sticky parity-failure flag |
| ovf_err | output | 1 | Sticky overflow flag |
| halted | output | 1 | Block has stopped after a parity failure |
| rd_valid | output | 1 | A word is available to read |
| rd_ready | input | 1 | Reader accepts the presented word |
| rd_data | output | 16 | Presented word |
| rd_soc | output | 1 | Presented word is the first of its cell |

## Verification
A parity failure can land on the 27th word of a cell, which is the same cycle that would commit the cell. The bench sends exactly that word twice. With halting on, it checks that `rd_valid` stays low and `halted` rises. With halting off, it checks that the cell becomes readable and `par_err` is set. The bench also fills the FIFO and sends a further whole cell into the full flag. It then checks `ovf_err` and reads back all four earlier cells word by word.

// File: rtl/utopia_rx_slave.sv
module utopia_rx_slave #(
  parameter int DW          = 16,
  parameter int CELL_WORDS  = 27,
  parameter int DEPTH_CELLS = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_en_n,
  input  logic [DW-1:0] rx_data,
  input  logic          rx_par,
  input  logic          rx_soc,
  input  logic          halt_on_par,
  input  logic          clr_status,
  output logic          cell_full,
  output logic          par_err,
  output logic          ovf_err,
  output logic          halted,
  output logic          rd_valid,
  input  logic          rd_ready,
  output logic [DW-1:0] rd_data,
  output logic          rd_soc
);
  localparam int NW   = CELL_WORDS * DEPTH_CELLS;
  localparam int AW   = $clog2(NW);
  localparam int CW   = (CELL_WORDS > 1) ? $clog2(CELL_WORDS) : 1;
  localparam int PW   = (DEPTH_CELLS > 1) ? $clog2(DEPTH_CELLS) : 1;
  localparam int CNTW = $clog2(DEPTH_CELLS + 1);

  logic [DW-1:0]   mem [NW];
  logic            in_cell;
  logic [CW-1:0]   wofs, rofs;
  logic [PW-1:0]   wcell, rcell;
  logic [CNTW-1:0] cnt;

  wire take     = !rx_en_n && !halted && !clr_status;
  wire bad      = ~^{rx_data, rx_par};
  wire drop_bad = take && bad && halt_on_par;
  wire accept   = take && !drop_bad && !cell_full;
  wire start    = accept && rx_soc;
  wire cont     = accept && !rx_soc && in_cell;
  wire wr       = start || cont;
  wire [CW-1:0] woff = start ? '0 : wofs;
  wire last     = wr && (woff == CW'(CELL_WORDS - 1));
  wire pop      = rd_valid && rd_ready;
  wire pop_last = pop && (rofs == CW'(CELL_WORDS - 1));

  wire [AW-1:0] wr_addr = AW'(wcell) * AW'(CELL_WORDS) + AW'(woff);
  wire [AW-1:0] rd_addr = AW'(rcell) * AW'(CELL_WORDS) + AW'(rofs);

  assign cell_full = (cnt == CNTW'(DEPTH_CELLS));
  assign rd_valid  = (cnt != '0);
  assign rd_data   = mem[rd_addr];
  assign rd_soc    = (rofs == '0);

  always_ff @(posedge clk)
    if (wr) mem[wr_addr] <= rx_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_cell <= 1'b0;
      wofs    <= '0;
      wcell   <= '0;
      rofs    <= '0;
      rcell   <= '0;
      cnt     <= '0;
      par_err <= 1'b0;
      ovf_err <= 1'b0;
      halted  <= 1'b0;
    end else begin
      if (clr_status || drop_bad || last) in_cell <= 1'b0;
      else if (start)                     in_cell <= 1'b1;

      if (wr) wofs <= woff + CW'(1);
      if (last) wcell <= (wcell == PW'(DEPTH_CELLS - 1)) ? '0 : wcell + PW'(1);

      if (pop) rofs <= pop_last ? '0 : rofs + CW'(1);
      if (pop_last) rcell <= (rcell == PW'(DEPTH_CELLS - 1)) ? '0 : rcell + PW'(1);

      cnt <= cnt + CNTW'(last) - CNTW'(pop_last);

      if (clr_status)       par_err <= 1'b0;
      else if (take && bad) par_err <= 1'b1;

      if (clr_status)             ovf_err <= 1'b0;
      else if (take && cell_full) ovf_err <= 1'b1;

      if (clr_status)    halted <= 1'b0;
      else if (drop_bad) halted <= 1'b1;
    end
  end
endmodule

// File: rtl/utopia_rx_slave_chk.sv
module utopia_rx_slave_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_en_n,
  input logic          clr_status,
  input logic          cell_full,
  input logic          par_err,
  input logic          ovf_err,
  input logic          halted,
  input logic          rd_valid,
  input logic          rd_ready,
  input logic [DW-1:0] rd_data,
  input logic          rd_soc
);
  // R1
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_en_n && !(rd_valid && rd_ready) |=> $stable(rd_valid) && $stable(cell_full));

  // R2
  par_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    par_err && !clr_status |=> par_err);

  // R3
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted && !clr_status |=> halted);

  // R7
  full_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cell_full |-> rd_valid);

  // R8
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_err && !clr_status |=> ovf_err);

  // R9
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_data) && $stable(rd_soc));

  // R10
  clr_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_status |=> !par_err && !ovf_err && !halted);
endmodule

bind utopia_rx_slave utopia_rx_slave_chk #(.DW(DW)) chk_i (.*);

// File: tb/utopia_rx_slave_test.sv
module utopia_rx_slave_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_en_n = 1'b1;
  logic [15:0] rx_data = '0;
  logic        rx_par = 1'b0;
  logic        rx_soc = 1'b0;
  logic        halt_on_par = 1'b0;
  logic        clr_status = 1'b0;
  logic        cell_full, par_err, ovf_err, halted, rd_valid, rd_soc;
  logic        rd_ready = 1'b0;
  logic [15:0] rd_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [16:0] exp_q[$];

  always #2 clk = ~clk;

  utopia_rx_slave uut (.*);

  task automatic check(input int act, input int exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic parbit(logic [15:0] d, logic bad);
    return bad ? ^d : ~^d;
  endfunction

  function automatic logic [15:0] cdata(int tagv, int k);
    return 16'(tagv * 37 + k * 1009) ^ 16'hA5C3;
  endfunction

  task automatic word(input logic [15:0] d, input logic soc, input logic bad);
    rx_en_n = 1'b0; rx_data = d; rx_soc = soc; rx_par = parbit(d, bad);
    @(negedge clk);
    rx_en_n = 1'b1; rx_soc = 1'b0; rx_data = 16'($urandom);
  endtask

  task automatic idle(input int n);
    rx_en_n = 1'b1; rx_data = 16'($urandom); rx_par = 1'($urandom); rx_soc = 1'($urandom);
    repeat (n) @(negedge clk);
    rx_soc = 1'b0;
  endtask

  task automatic send_cell(input int tagv, input int bad_at, input bit store, input bit gaps);
    for (int k = 0; k < 27; k++) begin
      word(cdata(tagv, k), k == 0, k == bad_at);
      if (store) exp_q.push_back({k == 0, cdata(tagv, k)});
      if (gaps && k < 26 && ($urandom % 4) == 0) idle(1 + $urandom % 2);
    end
  endtask

  task automatic drain(input int n, input bit stall);
    for (int i = 0; i < n; i++) begin
      if (stall && ($urandom % 3) == 0) begin
        rd_ready = 1'b0;
        @(negedge clk);
      end
      check(rd_valid, 1, "R9 valid during read");
      check({rd_soc, rd_data}, exp_q.pop_front(), "R9 read word");
      rd_ready = 1'b1;
      @(negedge clk);
    end
    rd_ready = 1'b0;
  endtask

  task automatic clear();
    clr_status = 1'b1;
    @(negedge clk);
    clr_status = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R11 reset state
    check(rd_valid, 0, "R11 rd_valid");
    check(cell_full, 0, "R11 cell_full");
    check(par_err, 0, "R11 par_err");
    check(ovf_err, 0, "R11 ovf_err");
    check(halted, 0, "R11 halted");

    // R5 words without an open cell are dropped; R1 junk with enable high ignored
    for (int k = 0; k < 3; k++) word(16'h1111 * 16'(k), 1'b0, 1'b0);
    idle(2);
    for (int k = 0; k < 27; k++) begin
      if (k == 26) check(rd_valid, 0, "R6 partial cell hidden");
      word(cdata(1, k), k == 0, 1'b0);
      exp_q.push_back({k == 0, cdata(1, k)});
      if (k == 10) idle(3);
    end
    check(rd_valid, 1, "R6 cell visible after last word");
    check(par_err, 0, "R1 junk did not raise parity");
    drain(27, 1'b0);
    check(rd_valid, 0, "R5 only one cell stored");

    // R5 start-of-cell mid-cell restarts framing
    for (int k = 0; k < 10; k++) word(cdata(2, k), k == 0, 1'b0);
    send_cell(3, -1, 1'b1, 1'b0);
    drain(27, 1'b0);
    check(rd_valid, 0, "R5 abandoned partial not stored");

    // R4 parity error without halt stores cell; R2 sticky flag
    halt_on_par = 1'b0;
    send_cell(4, 5, 1'b1, 1'b0);
    check(par_err, 1, "R2 par_err set");
    check(halted, 0, "R4 no halt");
    idle(3);
    check(par_err, 1, "R2 par_err sticky");
    drain(27, 1'b0);
    clear();
    check(par_err, 0, "R10 par_err cleared");

    // R3 halt discards partial and ignores further cells
    halt_on_par = 1'b1;
    for (int k = 0; k < 12; k++) word(cdata(5, k), k == 0, 1'b0);
    word(cdata(5, 12), 1'b0, 1'b1);
    check(halted, 1, "R3 halted");
    check(par_err, 1, "R3 par_err");
    send_cell(6, -1, 1'b0, 1'b0);
    check(rd_valid, 0, "R3 words ignored while halted");
    clear();
    check(halted, 0, "R10 halted cleared");
    for (int k = 0; k < 5; k++) word(cdata(7, k + 30), 1'b0, 1'b0);
    send_cell(7, -1, 1'b1, 1'b0);
    drain(27, 1'b0);
    check(rd_valid, 0, "R10 resync dropped words without soc");

    // corner: parity failure on the completing word
    send_cell(8, 26, 1'b0, 1'b0);
    check(rd_valid, 0, "R3 bad last word discards cell");
    check(halted, 1, "R3 halted on last word");
    clear();
    halt_on_par = 1'b0;
    send_cell(9, 26, 1'b1, 1'b0);
    check(rd_valid, 1, "R4 bad last word still commits");
    check(par_err, 1, "R2 par_err on last word");
    drain(27, 1'b0);
    clear();

    // R7 / R8 full flag and overflow
    send_cell(10, -1, 1'b1, 1'b0);
    send_cell(11, -1, 1'b1, 1'b0);
    send_cell(12, -1, 1'b1, 1'b0);
    check(cell_full, 0, "R7 three cells not full");
    send_cell(13, -1, 1'b1, 1'b1);
    check(cell_full, 1, "R7 four cells full");
    check(ovf_err, 0, "R8 no overflow yet");
    send_cell(14, -1, 1'b0, 1'b0);
    check(ovf_err, 1, "R8 overflow set");
    check(cell_full, 1, "R8 still full");
    drain(26, 1'b0);
    check(cell_full, 1, "R7 full until cell fully read");
    drain(1, 1'b0);
    check(cell_full, 0, "R7 full released");
    drain(81, 1'b1);
    check(rd_valid, 0, "R8 stored cells intact then empty");
    clear();
    check(ovf_err, 0, "R10 ovf cleared");

    // random traffic, halt off
    for (int it = 0; it < 30; it++) begin
      int bad_at;
      int tv;
      if (($urandom % 4) == 0) begin
        int n = 1 + $urandom % 20;
        tv = int'($urandom % 5000);
        for (int k = 0; k < n; k++) word(cdata(tv, k), k == 0, 1'b0);
      end
      bad_at = (($urandom % 3) == 0) ? int'($urandom % 27) : -1;
      tv = int'($urandom % 5000) + 100;
      send_cell(tv, bad_at, 1'b1, 1'b1);
      check(par_err, bad_at >= 0, "R2 random parity flag");
      if (bad_at >= 0) clear();
      drain(27, 1'b1);
      check(rd_valid, 0, "R9 random drained");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule